// File: doc/BRIEF.md
# Packed-SIMD Issue Gate with Aliased Tag Control

This block decides, one decoded instruction at a time, whether a packed-integer SIMD instruction may run on a core whose eight 64-bit SIMD registers overlay the floating-point register stack. It looks at the instruction class, its prefix bits, whether it has a memory operand, the emulation control bit and a pending floating-point exception flag. From these it produces a registered issue grant or one exception request: invalid opcode or numeric error.

The block owns the 16-bit floating-point tag word, which holds eight 2-bit fields. A granted SIMD instruction marks every field valid (00). A granted empty-state instruction marks every field empty (11). The block also formats register data for the two access widths. A 64-bit transfer passes all 64 bits unchanged. A 32-bit write into a SIMD register fills the upper half with zeros. A 32-bit read returns the low half. Bit 0 is the LSB, and byte k sits in bits 8k+7..8k (little endian).

Top module: `simd_issue_gate`

## Requirements
- R1: While reset is held, and in the first cycle after it, the tag word reads 16'hFFFF and every registered output reads 0.
- R2: When a SIMD instruction of class 1 (packed 64-bit), 2 (32-bit write into a SIMD register) or 3 (32-bit read from a SIMD register) is accepted with no exception condition, issue_grant is 1 in the next cycle and the tag word becomes 16'h0000 in that same cycle.
- R3: A granted class-4 instruction (empty-state) sets the tag word to 16'hFFFF.
- R4: A SIMD instruction (class 1 to 4) that carries the lock prefix raises exc_invalid in the next cycle, gets no grant and leaves the tag word unchanged.
- R5: With the emulation bit set, every SIMD instruction raises exc_invalid and is not granted. feature_flags bit 23 reads 1 whatever the emulation bit is.
- R6: With a floating-point exception pending and no invalid-opcode condition, a SIMD instruction raises exc_numeric, gets no grant and leaves the tag word unchanged.
- R7: At most one of issue_grant, exc_invalid and exc_numeric is 1 in any cycle. Invalid opcode takes priority over numeric error.
- R8: The operand-size and repeat prefixes change no output.
- R9: addr_size_eff and seg_ovr_eff are 1 only for a granted instruction that has a memory operand and carries the address-size or segment-override prefix, respectively.
- R10: A granted class-2 instruction gives wr_data = {32'h0, src32}.
- R11: A granted class-3 instruction gives int_data = src64[31:0]. A granted class-1 instruction gives wr_data = src64. Any cycle without a grant drives both to 0.
- R12: Outputs are one-cycle pulses. An idle cycle (instr_valid low, or class 0) drives every registered output to 0 and leaves the tag word unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| instr_valid | input | 1 | A decoded instruction is presented this cycle |
| op_class | input | 3 | 0 non-SIMD, 1 packed 64-bit, 2 32-bit write, 3 32-bit read, 4 empty-state |
| pfx_lock | input | 1 | Lock prefix present |
| pfx_opsize | input | 1 | Operand-size prefix present |
| pfx_rep | input | 1 | Repeat prefix present |
| pfx_addr | input | 1 | Address-size prefix present |
| pfx_seg | input | 1 | Segment-override prefix present |
| has_mem | input | 1 | Instruction has a memory operand |
| emu_bit | input | 1 | Emulation control bit |
| fp_exc_pending | input | 1 | Floating-point exception pending |
| src64 | input | 64 | 64-bit source value |
| src32 | input | 32 | 32-bit source value from an integer register or memory |
| issue_grant | output | 1 | Instruction issued (registered pulse) |
| exc_invalid | output | 1 | Invalid-opcode request (registered pulse) |
| exc_numeric | output | 1 | Numeric-error request (registered pulse) |
| addr_size_eff | output | 1 | Address-size prefix takes effect |
| seg_ovr_eff | output | 1 | Segment override takes effect |
| wr_data | output | 64 | Value written to the SIMD register |
| int_data | output | 32 | Value delivered to the integer side |
| tag_word | output | 16 | Floating-point tag word |
| feature_flags | output | 32 | Feature flags; bit 23 marks SIMD present |

## Verification
The hardest cases to reach are those where several blocking conditions hold at once, together with ignored prefixes, and the tag word is in a state where a wrong update would show. The bench sweeps every combination of class, five prefix bits, memory flag, emulation bit and pending exception in one pass, so the tag word before each case is whatever the previous case left. A model of the tag word tracks it, so any spurious update on a blocked instruction shows up as a mismatch. Directed sequences then set the tag word to all-valid before an empty-state instruction, and to all-empty before a blocked one.

// File: rtl/simd_gate_pkg.sv
package simd_gate_pkg;
   typedef enum logic [2:0] {
      OPC_NONE   = 3'd0,
      OPC_PACKED = 3'd1,
      OPC_WR32   = 3'd2,
      OPC_RD32   = 3'd3,
      OPC_EMPTY  = 3'd4
   } opc_e;

   typedef struct packed {
      logic grant;
      logic invalid;
      logic numeric;
   } verdict_t;
endpackage

// File: rtl/simd_issue_check.sv
module simd_issue_check
   import simd_gate_pkg::*;
(
   input  logic       valid_i,
   input  logic [2:0] opc_i,
   input  logic       lock_i,
   input  logic       emu_i,
   input  logic       fpexc_i,
   output logic       simd_o,
   output verdict_t   verdict_o
);
   logic blk_invalid;

   always_comb begin
      simd_o = valid_i && (opc_i == OPC_PACKED || opc_i == OPC_WR32 ||
                           opc_i == OPC_RD32   || opc_i == OPC_EMPTY);
      blk_invalid       = lock_i || emu_i;
      verdict_o.invalid = simd_o && blk_invalid;
      verdict_o.numeric = simd_o && !blk_invalid && fpexc_i;
      verdict_o.grant   = simd_o && !blk_invalid && !fpexc_i;
   end
endmodule

// File: rtl/simd_tag_ctrl.sv
module simd_tag_ctrl #(
   parameter int NUM_TAGS = 8,
   parameter int TAG_W    = 2,
   localparam int WORD_W  = NUM_TAGS * TAG_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              set_valid_i,
   input  logic              set_empty_i,
   output logic [WORD_W-1:0] tag_o
);
   localparam logic [TAG_W-1:0] TAG_VALID = '0;
   localparam logic [TAG_W-1:0] TAG_EMPTY = '1;

   if (NUM_TAGS < 1 || TAG_W < 1) begin : g_bad_cfg
      $error("simd_tag_ctrl: NUM_TAGS and TAG_W must be positive");
   end

   for (genvar i = 0; i < NUM_TAGS; i++) begin : g_field
      always_ff @(posedge clk) begin
         if (!rst_n)
            tag_o[i*TAG_W +: TAG_W] <= TAG_EMPTY;
         else if (set_empty_i)
            tag_o[i*TAG_W +: TAG_W] <= TAG_EMPTY;
         else if (set_valid_i)
            tag_o[i*TAG_W +: TAG_W] <= TAG_VALID;
      end
   end

   AST_TAG_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
      !(set_valid_i && set_empty_i)); // R3
   AST_TAG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !set_valid_i && !set_empty_i |=> tag_o == $past(tag_o)); // R12
endmodule

// File: rtl/simd_lane_fmt.sv
module simd_lane_fmt #(
   parameter int REG_W = 64,
   parameter int LOW_W = 32,
   localparam int BYTES     = REG_W / 8,
   localparam int LOW_BYTES = LOW_W / 8
) (
   input  logic             wr32_i,
   input  logic [REG_W-1:0] src64_i,
   input  logic [LOW_W-1:0] src32_i,
   output logic [REG_W-1:0] wr_o,
   output logic [LOW_W-1:0] low_o
);
   if (REG_W % 8 != 0 || LOW_W % 8 != 0 || LOW_W >= REG_W) begin : g_bad_cfg
      $error("simd_lane_fmt: widths must be whole bytes with LOW_W < REG_W");
   end

   for (genvar b = 0; b < BYTES; b++) begin : g_byte
      if (b < LOW_BYTES) begin : g_low
         assign wr_o[b*8 +: 8]  = wr32_i ? src32_i[b*8 +: 8] : src64_i[b*8 +: 8];
         assign low_o[b*8 +: 8] = src64_i[b*8 +: 8];
      end else begin : g_high
         assign wr_o[b*8 +: 8] = wr32_i ? 8'h00 : src64_i[b*8 +: 8];
      end
   end
endmodule

// File: rtl/simd_issue_gate.sv
module simd_issue_gate
   import simd_gate_pkg::*;
#(
   parameter int REG_W       = 64,
   parameter int LOW_W       = 32,
   parameter int NUM_TAGS    = 8,
   parameter int TAG_W       = 2,
   parameter int FLAGS_W     = 32,
   parameter int FEATURE_BIT = 23,
   localparam int TAGWORD_W  = NUM_TAGS * TAG_W
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 instr_valid,
   input  logic [2:0]           op_class,
   input  logic                 pfx_lock,
   input  logic                 pfx_opsize,
   input  logic                 pfx_rep,
   input  logic                 pfx_addr,
   input  logic                 pfx_seg,
   input  logic                 has_mem,
   input  logic                 emu_bit,
   input  logic                 fp_exc_pending,
   input  logic [REG_W-1:0]     src64,
   input  logic [LOW_W-1:0]     src32,
   output logic                 issue_grant,
   output logic                 exc_invalid,
   output logic                 exc_numeric,
   output logic                 addr_size_eff,
   output logic                 seg_ovr_eff,
   output logic [REG_W-1:0]     wr_data,
   output logic [LOW_W-1:0]     int_data,
   output logic [TAGWORD_W-1:0] tag_word,
   output logic [FLAGS_W-1:0]   feature_flags
);
   if (FEATURE_BIT < 0 || FEATURE_BIT >= FLAGS_W) begin : g_bad_flag
      $error("simd_issue_gate: FEATURE_BIT outside FLAGS_W");
   end

   logic             is_simd;
   verdict_t         vd;
   logic [REG_W-1:0] fmt_wr;
   logic [LOW_W-1:0] fmt_low;
   logic             is_wr32, is_rd32, is_packed, is_empty;

   assign is_wr32   = op_class == OPC_WR32;
   assign is_rd32   = op_class == OPC_RD32;
   assign is_packed = op_class == OPC_PACKED;
   assign is_empty  = op_class == OPC_EMPTY;

   simd_issue_check u_check (
      .valid_i   (instr_valid),
      .opc_i     (op_class),
      .lock_i    (pfx_lock),
      .emu_i     (emu_bit),
      .fpexc_i   (fp_exc_pending),
      .simd_o    (is_simd),
      .verdict_o (vd)
   );

   simd_tag_ctrl #(.NUM_TAGS(NUM_TAGS), .TAG_W(TAG_W)) u_tags (
      .clk         (clk),
      .rst_n       (rst_n),
      .set_valid_i (vd.grant && !is_empty),
      .set_empty_i (vd.grant && is_empty),
      .tag_o       (tag_word)
   );

   simd_lane_fmt #(.REG_W(REG_W), .LOW_W(LOW_W)) u_fmt (
      .wr32_i  (is_wr32),
      .src64_i (src64),
      .src32_i (src32),
      .wr_o    (fmt_wr),
      .low_o   (fmt_low)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         issue_grant   <= 1'b0;
         exc_invalid   <= 1'b0;
         exc_numeric   <= 1'b0;
         addr_size_eff <= 1'b0;
         seg_ovr_eff   <= 1'b0;
         wr_data       <= '0;
         int_data      <= '0;
      end else begin
         issue_grant   <= vd.grant;
         exc_invalid   <= vd.invalid;
         exc_numeric   <= vd.numeric;
         addr_size_eff <= vd.grant && has_mem && pfx_addr;
         seg_ovr_eff   <= vd.grant && has_mem && pfx_seg;
         wr_data       <= (vd.grant && (is_packed || is_wr32)) ? fmt_wr : '0;
         int_data      <= (vd.grant && is_rd32) ? fmt_low : '0;
      end
   end

   always_comb begin
      feature_flags              = '0;
      feature_flags[FEATURE_BIT] = 1'b1;
   end

   AST_ONE_VERDICT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({issue_grant, exc_invalid, exc_numeric})); // R7
   AST_LOCK_INVALID: assert property (@(posedge clk) disable iff (!rst_n)
      is_simd && pfx_lock |=> exc_invalid && !issue_grant); // R4
   AST_EMU_INVALID: assert property (@(posedge clk) disable iff (!rst_n)
      is_simd && emu_bit |=> exc_invalid && !exc_numeric); // R5
   AST_NUMERIC_NO_TAG: assert property (@(posedge clk) disable iff (!rst_n)
      exc_numeric |-> tag_word == $past(tag_word)); // R6
   AST_GRANT_VALID: assert property (@(posedge clk) disable iff (!rst_n)
      is_simd && !is_empty && !pfx_lock && !emu_bit && !fp_exc_pending
      |=> issue_grant && tag_word == '0); // R2
   AST_PREFIX_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      is_simd && (pfx_opsize || pfx_rep) && !pfx_lock && !emu_bit && !fp_exc_pending
      |=> issue_grant); // R8
   AST_NOMEM_NO_EFF: assert property (@(posedge clk) disable iff (!rst_n)
      !has_mem |=> !addr_size_eff && !seg_ovr_eff); // R9
   AST_WR32_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      vd.grant && is_wr32 |=> wr_data[REG_W-1:LOW_W] == '0); // R10
endmodule

// File: tb/simd_issue_gate_tb_top.sv
module simd_issue_gate_tb_top;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        instr_valid;
   logic [2:0]  op_class;
   logic        pfx_lock, pfx_opsize, pfx_rep, pfx_addr, pfx_seg;
   logic        has_mem, emu_bit, fp_exc_pending;
   logic [63:0] src64;
   logic [31:0] src32;
   logic        issue_grant, exc_invalid, exc_numeric, addr_size_eff, seg_ovr_eff;
   logic [63:0] wr_data;
   logic [31:0] int_data;
   logic [15:0] tag_word;
   logic [31:0] feature_flags;

   int checks = 0;
   int fails  = 0;
   logic [15:0] m_tag;

   always #(CLK_PERIOD/2) clk = ~clk;

   simd_issue_gate dut_i (
      .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .op_class(op_class),
      .pfx_lock(pfx_lock), .pfx_opsize(pfx_opsize), .pfx_rep(pfx_rep),
      .pfx_addr(pfx_addr), .pfx_seg(pfx_seg), .has_mem(has_mem),
      .emu_bit(emu_bit), .fp_exc_pending(fp_exc_pending),
      .src64(src64), .src32(src32), .issue_grant(issue_grant),
      .exc_invalid(exc_invalid), .exc_numeric(exc_numeric),
      .addr_size_eff(addr_size_eff), .seg_ovr_eff(seg_ovr_eff),
      .wr_data(wr_data), .int_data(int_data), .tag_word(tag_word),
      .feature_flags(feature_flags)
   );

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic drive(input logic v, input logic [2:0] opc, input logic [7:0] bits);
      @(negedge clk);
      instr_valid = v; op_class = opc;
      {pfx_lock, pfx_opsize, pfx_rep, pfx_addr, pfx_seg, has_mem, emu_bit, fp_exc_pending} = bits;
      @(posedge clk); #1;
   endtask

   // Verifies registered outputs against the arithmetic model after one instruction.
   task automatic run_case(input logic [2:0] opc, input logic [7:0] bits);
      logic simd, inv, num, gr, lk, emu, fpx, mem, pa, ps;
      string r;
      {lk, pa, ps, mem, emu, fpx} = {bits[7], bits[4], bits[3], bits[2], bits[1], bits[0]};
      simd = (opc >= 3'd1 && opc <= 3'd4);
      inv  = simd && (lk || emu);
      num  = simd && !inv && fpx;
      gr   = simd && !inv && !num;
      if (gr) m_tag = (opc == 3'd4) ? 16'hFFFF : 16'h0000;
      src64 = {$urandom, $urandom}; src32 = $urandom;
      drive(1'b1, opc, bits);
      r = inv ? (lk ? "R4" : "R5") : num ? "R6" : gr ? ((opc == 3'd4) ? "R3" : "R2") : "R12";
      chk({r, " grant"}, 64'(issue_grant), 64'(gr));
      chk({r, " invalid R7"}, 64'(exc_invalid), 64'(inv));
      chk({r, " numeric R7"}, 64'(exc_numeric), 64'(num));
      chk({r, " tag"}, 64'(tag_word), 64'(m_tag));
      chk("R9 addr", 64'(addr_size_eff), 64'(gr && mem && pa));
      chk("R9 seg", 64'(seg_ovr_eff), 64'(gr && mem && ps));
      chk("R10 R11 wr_data", wr_data,
          !gr ? 64'h0 : (opc == 3'd1) ? src64 : (opc == 3'd2) ? {32'h0, src32} : 64'h0);
      chk("R11 int_data", 64'(int_data), (gr && opc == 3'd3) ? 64'(src64[31:0]) : 64'h0);
      chk("R5 feature bit", 64'(feature_flags[23]), 64'h1);
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      fails++;
      $display("FAIL watchdog R12 actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      rst_n = 1'b0; instr_valid = 1'b0; op_class = 3'd0;
      {pfx_lock, pfx_opsize, pfx_rep, pfx_addr, pfx_seg, has_mem, emu_bit, fp_exc_pending} = '0;
      src64 = 64'h0; src32 = 32'h0;
      m_tag = 16'hFFFF;
      repeat (3) @(posedge clk);
      #1;
      chk("R1 tag reset", 64'(tag_word), 64'hFFFF);
      chk("R1 outputs reset", 64'({issue_grant, exc_invalid, exc_numeric, addr_size_eff, seg_ovr_eff}), 64'h0);
      chk("R1 data reset", wr_data | 64'(int_data), 64'h0);
      @(negedge clk); rst_n = 1'b1;
      @(posedge clk); #1;
      chk("R1 first cycle", 64'({issue_grant, tag_word}), 64'hFFFF);

      // Full sweep: every class and every prefix/flag combination.
      for (int opc = 0; opc < 5; opc++)
         for (int b = 0; b < 256; b++)
            run_case(3'(opc), 8'(b));

      // R8: operand-size/repeat prefixes give identical outcome to plain.
      run_case(3'd1, 8'b0000_0000);
      run_case(3'd4, 8'b0110_0000);
      chk("R8 tag after prefixed empty-state", 64'(tag_word), 64'hFFFF);
      run_case(3'd2, 8'b0110_0000);
      chk("R8 R10 prefixed wr32 tags valid", 64'(tag_word), 64'h0);

      // R3 from all-valid; R7 priority with all conditions present.
      run_case(3'd4, 8'b0000_0000);
      run_case(3'd1, 8'b1000_0011);
      chk("R7 invalid wins over numeric", 64'({exc_invalid, exc_numeric}), 64'b10);
      run_case(3'd1, 8'b0000_0001);
      chk("R6 tag kept empty", 64'(tag_word), 64'hFFFF);

      // R12: idle cycle clears pulses after a grant.
      run_case(3'd1, 8'b0001_0100);
      drive(1'b0, 3'd1, 8'h00);
      chk("R12 idle pulses", 64'({issue_grant, exc_invalid, exc_numeric, addr_size_eff, seg_ovr_eff}), 64'h0);
      chk("R12 idle data", wr_data | 64'(int_data), 64'h0);
      chk("R12 idle tag", 64'(tag_word), 64'h0);

      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule